// File: doc/BRIEF.md
# Indexed Dual-Bank CMOS RAM Port

This block sits behind a simple host I/O bus and gives indexed access to 256 bytes of battery-backed storage. The storage is split into a standard bank and an extended bank of 128 bytes each. The I/O bus supplies an 8-bit port address, read and write strobes, and 8-bit data. Eight consecutive ports, starting at a base address, are decoded into an index port and a data port for each bank. Every port also answers at a second alias address.

Software first writes a bank's index port to select a location. It then reads or writes that bank's data port. The index does not advance by itself after an access.

Standard-bank locations below the register window size (14 by default) are not held in the array. They hold time, date and configuration registers that live outside this block, so accesses to them are forwarded on a small register interface. Writes to the standard index port also capture an NMI-enable bit. A bank-enable input selects how the upper port pair behaves: it either reaches the extended bank or acts as a second copy of the standard pair. A clock-off input blocks the standard data port and leaves the extended bank usable.

Top module: `cmos_index_port`

## Requirements
- R1: With base 70h, a write to port 70h or 74h sets the standard index. Ports 71h and 75h read the standard-bank byte at that index in the same cycle as the read strobe, and a write updates that byte on the write strobe. The index never changes as a side effect of a data access.
- R2: With bankEn=1, ports 72h/76h set the extended index, and ports 73h/77h read and write the extended bank. The extended bank is storage separate from the standard bank. An extended index write leaves nmiEn unchanged.
- R3: With bankEn=0, ports 72h/76h behave exactly like the standard index port, including the NMI capture. Ports 73h/77h behave exactly like the standard data port.
- R4: A standard data access whose index is below 14 goes to the register interface instead of the array. regSel equals the index, regRd or regWr is high for that cycle, regWrData carries the written byte, and a read returns regRdData.
- R5: A write to the standard index port loads bit 7 into nmiEn and bits 6:0 into the index. nmiEn changes at no other time.
- R6: A read of port 70h, or of 72h, returns FFh. A read of 74h returns the standard index with bit 7 forced to 0. A read of 76h with bankEn=1 returns the extended index with bit 7 forced to 0.
- R7: Bit 7 of an extended index write is ignored, so index values v and v+80h reach the same extended byte.
- R8: With clkOff=1, standard data port reads return FFh and standard data port writes change nothing. Index writes and the whole extended bank keep working.
- R9: A read of a port outside the eight decoded ports returns FFh. A write to such a port changes no index, no byte and not nmiEn. Reads never change any state.
- R10: After reset, both indices and nmiEn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioAddr | input | 8 | I/O port address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, combinational; FFh when nothing is selected |
| bankEn | input | 1 | 1: upper port pair reaches the extended bank; 0: upper pair aliases the standard pair |
| clkOff | input | 1 | Clock function disabled; blocks the standard data port |
| nmiEn | output | 1 | Captured NMI-enable bit |
| regSel | output | 4 | Register-window location |
| regRd | output | 1 | Register-window read strobe |
| regWr | output | 1 | Register-window write strobe |
| regWrData | output | 8 | Register-window write data |
| regRdData | input | 8 | Register-window read data |

## Verification
The bench builds the block with its default parameters: base port 70h, 7-bit indices and a 14-entry register window. These values let random addresses in the range 6Ch to 7Bh hit every decoded port, both of its aliases and the undecoded neighbours on either side. Random indices land both inside the register window and in the array, and extended index values with bit 7 set exercise the wrap. Toggling bankEn and clkOff during the random run brings aliasing changes and the blocked standard data port into reach against a bench model of both banks and the register file.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_STD_IDX = 3'd1,
    RD_EXT_IDX = 3'd2,
    RD_RAM     = 3'd3,
    RD_REG     = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic   ramWe;
    logic   regRd;
    logic   regWr;
    rdSrc_e rdSrc;
  } portStb_t;

endpackage

// File: rtl/cmos_port_ctrl.sv
module cmos_port_ctrl
  import cmos_port_pkg::*;
#(
  parameter int IO_AW     = 8,
  parameter int DW        = 8,
  parameter int IDX_W     = 7,
  parameter int REG_WIN   = 14,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h70,
  localparam int RAM_AW   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DW-1:0]     ioWrData,
  input  logic              bankEn,
  input  logic              clkOff,
  output portStb_t          stb,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [IDX_W-1:0]  stdIdx,
  output logic [IDX_W-1:0]  extIdx,
  output logic              nmiEn
);

  // Decode the eight-port window; the low three address bits select the port.
  logic       portHit;
  logic       aliasHi;
  logic [1:0] portSel;
  logic       isStdIdx, isStdData, isExtIdx, isExtData;
  logic       inWin;
  logic       rdOnly;

  assign portHit = (ioAddr[IO_AW-1:3] == PORT_BASE[IO_AW-1:3]);
  assign aliasHi = ioAddr[2];

  // With the extended bank off, the upper pair folds onto the standard pair.
  always_comb begin
    portSel = ioAddr[1:0];
    if (!bankEn) portSel[1] = 1'b0;
  end

  assign isStdIdx  = portHit && (portSel == 2'd0);
  assign isStdData = portHit && (portSel == 2'd1);
  assign isExtIdx  = portHit && (portSel == 2'd2);
  assign isExtData = portHit && (portSel == 2'd3);

  assign inWin  = (int'(stdIdx) < REG_WIN);
  assign rdOnly = ioRd && !ioWr;

  // Index and NMI-enable registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stdIdx <= '0;
      extIdx <= '0;
      nmiEn  <= 1'b0;
    end else if (ioWr) begin
      if (isStdIdx) begin
        stdIdx <= ioWrData[IDX_W-1:0];
        nmiEn  <= ioWrData[DW-1];
      end
      if (isExtIdx) begin
        extIdx <= ioWrData[IDX_W-1:0];
      end
    end
  end

  // Strobe generation toward the datapath.
  always_comb begin
    stb       = '0;
    stb.rdSrc = RD_NONE;
    ramAddr   = {1'b0, stdIdx};
    if (isExtData) begin
      ramAddr = {1'b1, extIdx};
      stb.ramWe = ioWr;
      if (rdOnly) stb.rdSrc = RD_RAM;
    end else if (isStdData && !clkOff) begin
      if (inWin) begin
        stb.regWr = ioWr;
        stb.regRd = rdOnly;
        if (rdOnly) stb.rdSrc = RD_REG;
      end else begin
        stb.ramWe = ioWr;
        if (rdOnly) stb.rdSrc = RD_RAM;
      end
    end else if (isStdIdx && aliasHi && rdOnly) begin
      stb.rdSrc = RD_STD_IDX;
    end else if (isExtIdx && aliasHi && rdOnly) begin
      stb.rdSrc = RD_EXT_IDX;
    end
  end

endmodule

// File: rtl/cmos_port_dp.sv
module cmos_port_dp
  import cmos_port_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IDX_W     = 7,
  parameter int REG_WIN   = 14,
  localparam int RAM_AW   = IDX_W + 1,
  localparam int RAM_DEPTH = 1 << RAM_AW,
  localparam int REG_SEL_W = $clog2(REG_WIN)
) (
  input  logic                 clk,
  input  portStb_t             stb,
  input  logic [RAM_AW-1:0]    ramAddr,
  input  logic [IDX_W-1:0]     stdIdx,
  input  logic [IDX_W-1:0]     extIdx,
  input  logic [DW-1:0]        ioWrData,
  input  logic [DW-1:0]        regRdData,
  output logic [DW-1:0]        ioRdData,
  output logic [REG_SEL_W-1:0] regSel,
  output logic [DW-1:0]        regWrData
);

  // Battery-backed contents carry no reset.
  logic [DW-1:0] ramArr [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (stb.ramWe) ramArr[ramAddr] <= ioWrData;
  end

  assign regSel    = stdIdx[REG_SEL_W-1:0];
  assign regWrData = ioWrData;

  always_comb begin
    unique case (stb.rdSrc)
      RD_STD_IDX: ioRdData = DW'(stdIdx);
      RD_EXT_IDX: ioRdData = DW'(extIdx);
      RD_RAM:     ioRdData = ramArr[ramAddr];
      RD_REG:     ioRdData = regRdData;
      default:    ioRdData = '1;
    endcase
  end

endmodule

// File: rtl/cmos_index_port.sv
module cmos_index_port
  import cmos_port_pkg::*;
#(
  parameter int IO_AW     = 8,
  parameter int DW        = 8,
  parameter int IDX_W     = 7,
  parameter int REG_WIN   = 14,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h70,
  localparam int RAM_AW    = IDX_W + 1,
  localparam int REG_SEL_W = $clog2(REG_WIN)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IO_AW-1:0]     ioAddr,
  input  logic                 ioRd,
  input  logic                 ioWr,
  input  logic [DW-1:0]        ioWrData,
  output logic [DW-1:0]        ioRdData,
  input  logic                 bankEn,
  input  logic                 clkOff,
  output logic                 nmiEn,
  output logic [REG_SEL_W-1:0] regSel,
  output logic                 regRd,
  output logic                 regWr,
  output logic [DW-1:0]        regWrData,
  input  logic [DW-1:0]        regRdData
);

  portStb_t          stb;
  logic [RAM_AW-1:0] ramAddr;
  logic [IDX_W-1:0]  stdIdx;
  logic [IDX_W-1:0]  extIdx;

  cmos_port_ctrl #(
    .IO_AW(IO_AW), .DW(DW), .IDX_W(IDX_W), .REG_WIN(REG_WIN), .PORT_BASE(PORT_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .bankEn(bankEn), .clkOff(clkOff), .stb(stb),
    .ramAddr(ramAddr), .stdIdx(stdIdx), .extIdx(extIdx), .nmiEn(nmiEn)
  );

  cmos_port_dp #(
    .DW(DW), .IDX_W(IDX_W), .REG_WIN(REG_WIN)
  ) uDp (
    .clk(clk), .stb(stb), .ramAddr(ramAddr), .stdIdx(stdIdx), .extIdx(extIdx),
    .ioWrData(ioWrData), .regRdData(regRdData), .ioRdData(ioRdData),
    .regSel(regSel), .regWrData(regWrData)
  );

  assign regRd = stb.regRd;
  assign regWr = stb.regWr;

endmodule

// File: rtl/cmos_port_checker.sv
module cmos_port_checker #(
  parameter int IO_AW     = 8,
  parameter int DW        = 8,
  parameter int REG_WIN   = 14,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'h70,
  localparam int REG_SEL_W = $clog2(REG_WIN)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [IO_AW-1:0]     ioAddr,
  input logic                 ioRd,
  input logic                 ioWr,
  input logic [DW-1:0]        ioWrData,
  input logic [DW-1:0]        ioRdData,
  input logic                 bankEn,
  input logic                 clkOff,
  input logic                 nmiEn,
  input logic [REG_SEL_W-1:0] regSel,
  input logic                 regRd,
  input logic                 regWr
);

  logic inRange;
  logic nmiPortWr;

  assign inRange   = (ioAddr[IO_AW-1:3] == PORT_BASE[IO_AW-1:3]);
  assign nmiPortWr = ioWr && inRange &&
                     ((ioAddr[1:0] == 2'd0) || (!bankEn && ioAddr[1:0] == 2'd2));

  AST_NMI_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    nmiPortWr |=> nmiEn == $past(ioWrData[DW-1]));                        // R5

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !nmiPortWr |=> $stable(nmiEn));                                        // R5

  AST_LEGACY_IDX_FF: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && ioAddr == PORT_BASE) |-> ioRdData == '1);           // R6

  AST_ALIAS_IDX_BIT7: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && ioAddr == (PORT_BASE | IO_AW'(4))) |-> !ioRdData[DW-1]); // R6

  AST_UNDECODED_FF: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && !inRange) |-> ioRdData == '1);                      // R9

  AST_REG_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) |-> (inRange && int'(regSel) < REG_WIN &&
                          ioAddr[0] && !clkOff));                          // R4

  AST_REG_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regRd, regWr}));                                             // R4

  AST_CLKOFF_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    clkOff |-> !(regRd || regWr));                                         // R8

endmodule

bind cmos_index_port cmos_port_checker #(
  .IO_AW(IO_AW), .DW(DW), .REG_WIN(REG_WIN), .PORT_BASE(PORT_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .bankEn(bankEn), .clkOff(clkOff),
  .nmiEn(nmiEn), .regSel(regSel), .regRd(regRd), .regWr(regWr)
);

// File: tb/sim_cmos_index_port.sv
module sim_cmos_index_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ioAddr = 8'h00;
  logic       ioRd = 1'b0;
  logic       ioWr = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdData;
  logic       bankEn = 1'b1;
  logic       clkOff = 1'b0;
  logic       nmiEn;
  logic [3:0] regSel;
  logic       regRd;
  logic       regWr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  cmos_index_port u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .bankEn(bankEn), .clkOff(clkOff),
    .nmiEn(nmiEn), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // External register block stub, driven only by the design's strobes.
  logic [7:0] regStub [14];
  assign regRdData = (regSel < 4'd14) ? regStub[regSel] : 8'h00;
  always_ff @(posedge clk) if (regWr && regSel < 4'd14) regStub[regSel] <= regWrData;

  // Expected-state model.
  logic [7:0] mStd [128];
  logic [7:0] mExt [128];
  logic [7:0] mReg [14];
  logic [6:0] mStdIdx = 0, mExtIdx = 0;
  logic       mNmi = 0;

  function automatic logic [1:0] portOf(input logic [7:0] a);
    logic [1:0] p = a[1:0];
    if (!bankEn) p[1] = 1'b0;
    return p;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a[7:3] != 5'h0E) return 8'hFF;
    case (portOf(a))
      2'd0: return a[2] ? {1'b0, mStdIdx} : 8'hFF;
      2'd2: return a[2] ? {1'b0, mExtIdx} : 8'hFF;
      2'd1: begin
        if (clkOff) return 8'hFF;
        if (mStdIdx < 7'd14) return mReg[mStdIdx[3:0]];
        return mStd[mStdIdx];
      end
      default: return mExt[mExtIdx];
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    if (a[7:3] != 5'h0E) return;
    case (portOf(a))
      2'd0: begin mStdIdx = d[6:0]; mNmi = d[7]; end
      2'd2: mExtIdx = d[6:0];
      2'd1: if (!clkOff) begin
        if (mStdIdx < 7'd14) mReg[mStdIdx[3:0]] = d;
        else mStd[mStdIdx] = d;
      end
      default: mExt[mExtIdx] = d;
    endcase
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic ioReadChk(input logic [7:0] a, input string req);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #2;
    check(req, ioRdData, expRead(a));
    ioRd = 1'b0;
  endtask

  task automatic nmiChk(input string req);
    #1;
    check(req, {7'd0, nmiEn}, {7'd0, mNmi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0070));
    for (int i = 0; i < 14; i++) begin regStub[i] = 8'h00; mReg[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    nmiChk("R10 nmiEn");
    ioReadChk(8'h74, "R10 std index");
    ioReadChk(8'h76, "R10 ext index");

    // Fill both banks so every later read has a known value.
    for (int i = 14; i < 128; i++) begin
      ioWrite(8'h70, 8'(i));
      ioWrite(8'h71, 8'(i * 3 + 1));
    end
    for (int i = 0; i < 128; i++) begin
      ioWrite(8'h72, 8'(i));
      ioWrite(8'h73, 8'(i ^ 8'h5A));
    end
    for (int i = 0; i < 14; i++) begin
      ioWrite(8'h70, 8'(i));
      ioWrite(8'h71, 8'(8'hA0 + i));
    end

    // R5: NMI capture, R4: register window
    ioWrite(8'h70, 8'h8A);
    nmiChk("R5 nmi set");
    ioReadChk(8'h74, "R6 bit7 masked");
    ioReadChk(8'h71, "R4 reg window read");
    ioWrite(8'h75, 8'h3C);
    ioReadChk(8'h71, "R4 reg window write");
    ioReadChk(8'h70, "R6 port70 FF");

    // R1: array access, no auto-increment
    ioWrite(8'h74, 8'h20);
    nmiChk("R5 nmi clear");
    ioWrite(8'h71, 8'h55);
    ioReadChk(8'h75, "R1 data alias");
    ioReadChk(8'h71, "R1 no increment");
    ioReadChk(8'h74, "R1 index kept");

    // R2/R7: extended bank
    bankEn = 1'b1;
    ioWrite(8'h72, 8'h85);
    nmiChk("R2 ext idx leaves nmi");
    ioWrite(8'h73, 8'hC3);
    ioReadChk(8'h77, "R2 ext data");
    ioReadChk(8'h76, "R7 ext bit7 dropped");
    ioWrite(8'h76, 8'h05);
    ioReadChk(8'h73, "R7 wrap");
    ioReadChk(8'h72, "R6 port72 FF");
    ioReadChk(8'h71, "R2 std untouched");

    // R3: aliasing with the extended bank off
    bankEn = 1'b0;
    ioWrite(8'h76, 8'hB0);
    nmiChk("R3 alias nmi");
    ioReadChk(8'h74, "R3 alias index");
    ioWrite(8'h73, 8'h11);
    ioReadChk(8'h71, "R3 alias data");
    bankEn = 1'b1;
    ioReadChk(8'h73, "R3 ext kept");

    // R8: clock function off
    clkOff = 1'b1;
    ioReadChk(8'h71, "R8 std blocked read");
    ioWrite(8'h71, 8'h99);
    ioReadChk(8'h73, "R8 ext alive");
    ioWrite(8'h70, 8'h03);
    ioReadChk(8'h74, "R8 index alive");
    clkOff = 1'b0;
    ioReadChk(8'h71, "R8 write ignored");
    ioWrite(8'h70, 8'h30);
    ioReadChk(8'h71, "R8 array write ignored");

    // R9: undecoded ports
    ioReadChk(8'h6F, "R9 below window");
    ioReadChk(8'h78, "R9 above window");
    ioWrite(8'h78, 8'hFF);
    ioWrite(8'h6C, 8'h80);
    nmiChk("R9 nmi untouched");
    ioReadChk(8'h74, "R9 index untouched");
    ioReadChk(8'h71, "R9 data untouched");

    // Random phase
    for (int n = 0; n < 800; n++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = 8'h6C + 8'($urandom % 16);
      d = 8'($urandom);
      if ($urandom % 20 == 0) bankEn = ~bankEn;
      if ($urandom % 25 == 0) clkOff = ~clkOff;
      if ($urandom % 2 == 0) begin
        ioWrite(a, d);
        nmiChk("R5 random nmi");
      end else begin
        ioReadChk(a, "R1-R9 random read");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule